// File: doc/BRIEF.md
# Pen-Interrupt Scan Pacer

This block sits between the pen-down interrupt line of a resistive touch converter and the engine that runs a conversion scan over the serial link. It turns the level-type, active-low interrupt into single-cycle scan-start pulses. After every scan it holds the interrupt masked, so consecutive scans stay roughly one scan interval apart. The hold is the interval minus the measured scan time.

When a scan was started by the pen, re-arming also starts a one-shot timer. The timer runs for the interval rounded up to whole milliseconds. If the pen has lifted, the interrupt no longer fires, and the timer supplies exactly one further scan so that the released state is captured. A scan started by the timer does not restart the timer, so the block then goes quiet until the pen touches again. Only one scan is outstanding at a time, and the block waits for the scan engine's done strobe before it issues another start.

Time is measured in microseconds by a free-running prescaler that divides the system clock. The enable input stops the pacing: when it is low the interrupt stays masked and any pending timer is dropped.

Top module: `pen_scan_pacer`

## Requirements
- R1: While reset is held, and afterwards while `en` is low, `scan_start` is 0 and `irq_masked` is 1.
- R2: `en` rising unmasks the interrupt at the next clock edge. `en` low masks it at the next edge. While `en` is low the pen input causes no scan start.
- R3: `pen_n` is active low and passes through a two-flop synchronizer. With the interrupt unmasked, a falling `pen_n` produces a one-cycle `scan_start` on the third rising edge after the fall. `irq_masked` rises on that same edge.
- R4: Between a `scan_start` and the following `scan_done`, no further `scan_start` is issued, whatever the pen level.
- R5: On `scan_done`, when D = INTERVAL_US minus `scan_dur_us` is positive, the interrupt stays masked for D microseconds. Measured in edges after the done edge, this is between (D-1)*CLK_PER_US+1 and D*CLK_PER_US. When D is not positive, the interrupt unmasks on the done edge itself.
- R6: A re-arm with a zero extra-scan count starts a one-shot timer of ceil(INTERVAL_US/1000)*1000 microseconds. When that re-arm ends a hold, the timer's scan start comes exactly that many microseconds, in clock cycles, after `irq_masked` falls, provided the pen stays released.
- R7: A timer-started scan increments the extra-scan count. The re-arm after it starts no timer, so without pen activity no further scan occurs.
- R8: A pen interrupt while the timer is pending cancels the timer and clears the extra-scan count. The next re-arm starts a fresh full timer.
- R9: Disabling cancels a pending timer. After re-enabling, no timer-driven scan occurs.
- R10: If the pen interrupt and the timer expiry fall in the same cycle, exactly one scan start is issued. It is taken as a pen scan, so the count is cleared and the next re-arm starts the timer again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Pacing enable |
| pen_n | input | 1 | Pen-down interrupt level, active low, asynchronous |
| scan_done | input | 1 | One-cycle strobe: the outstanding scan finished |
| scan_dur_us | input | DUR_W | Duration of the finished scan in microseconds, valid with `scan_done` |
| scan_start | output | 1 | One-cycle request to begin a scan |
| irq_masked | output | 1 | High while the pen interrupt is masked |

## Verification
The bench measures the unmask latency after each scan over durations below, equal to and above the interval. A wrong subtraction or a wrong sign test would unmask too early or hold the interrupt for a wrap-around time. It times the single timer-driven scan to the exact cycle, then checks that a second timer scan never comes; a timer that re-arms itself would scan forever. A pen pulse while the timer is pending, and a disable/enable cycle, must both kill the old timer, which would otherwise fire early or after re-enable. A pen pulse placed on the expiry cycle must count as a pen scan, which shows up as a new timer run after the following re-arm.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ARMED = 2'd1,
    ST_BUSY  = 2'd2,
    ST_HOLD  = 2'd3
  } pst_state_e;

  function automatic int unsigned ms_ceil_us(input int unsigned us);
    return ((us + 999) / 1000) * 1000;
  endfunction
endpackage

// File: rtl/pst_sync2.sv
module pst_sync2 #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pst_us_tick.sv
module pst_us_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] div_q, div_d;
      logic          at_end;

      always_comb begin
        at_end = (div_q == CW'(DIV - 1));
        div_d  = at_end ? '0 : div_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      assign tick = at_end;
    end
  endgenerate
endmodule

// File: rtl/pst_countdown.sv
module pst_countdown #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cancel,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;
  logic         upd;

  always_comb begin
    expire = run_q && tick && (cnt_q == W'(1));
    cnt_d  = cnt_q;
    run_d  = run_q;
    upd    = 1'b0;
    if (cancel) begin
      cnt_d = '0;
      run_d = 1'b0;
      upd   = 1'b1;
    end else if (load) begin
      cnt_d = load_val;
      run_d = (load_val != '0);
      upd   = 1'b1;
    end else if (run_q && tick) begin
      cnt_d = cnt_q - 1'b1;
      run_d = !expire;
      upd   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/pen_scan_pacer.sv
module pen_scan_pacer
  import pst_pkg::*;
#(
  parameter int CLK_PER_US  = 50,
  parameter int INTERVAL_US = 10000,
  parameter int DUR_W       = 16,
  parameter int XCNT_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pen_n,
  input  logic             scan_done,
  input  logic [DUR_W-1:0] scan_dur_us,
  output logic             scan_start,
  output logic             irq_masked
);
  localparam int unsigned ONESHOT_US = ms_ceil_us(INTERVAL_US);
  localparam int          TW         = $clog2(ONESHOT_US + 1);

  logic rst_sync_n;
  logic pen_lvl, pen_act, tick;

  pst_sync2 #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  pst_sync2 #(.STAGES(2), .RST_VAL(1'b1)) u_pen_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pen_n), .q(pen_lvl)
  );
  assign pen_act = !pen_lvl;

  pst_us_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick)
  );

  // hold-off timer and one-shot extra-scan timer
  logic          dl_load, dl_expire;
  logic [TW-1:0] dl_val;
  logic          os_load, os_cancel, os_expire;

  pst_countdown #(.W(TW)) u_hold_tmr (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .cancel(!en),
    .load(dl_load), .load_val(dl_val), .expire(dl_expire)
  );

  pst_countdown #(.W(TW)) u_extra_tmr (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .cancel(os_cancel),
    .load(os_load), .load_val(TW'(ONESHOT_US)), .expire(os_expire)
  );

  // hold length: interval minus the measured scan time, if positive
  logic [31:0] dur_ext;
  logic        hold_pos;
  always_comb begin
    dur_ext  = 32'(scan_dur_us);
    hold_pos = dur_ext < 32'(INTERVAL_US);
    dl_val   = TW'(32'(INTERVAL_US) - dur_ext);
  end

  pst_state_e        st_q, st_d;
  logic [XCNT_W-1:0] xcnt_q, xcnt_d;
  logic              xcnt_en;
  logic              start_q, start_d;
  logic              rearm;

  always_comb begin
    st_d      = st_q;
    xcnt_d    = xcnt_q;
    xcnt_en   = 1'b0;
    start_d   = 1'b0;
    dl_load   = 1'b0;
    os_load   = 1'b0;
    os_cancel = !en;
    rearm     = 1'b0;
    if (!en) begin
      st_d = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF:   st_d = ST_ARMED;
        ST_ARMED: begin
          if (pen_act) begin
            start_d   = 1'b1;
            os_cancel = 1'b1;
            xcnt_d    = '0;
            xcnt_en   = 1'b1;
            st_d      = ST_BUSY;
          end else if (os_expire) begin
            start_d = 1'b1;
            if (xcnt_q != '1) begin
              xcnt_d  = xcnt_q + 1'b1;
              xcnt_en = 1'b1;
            end
            st_d = ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (scan_done) begin
            if (hold_pos) begin
              dl_load = 1'b1;
              st_d    = ST_HOLD;
            end else begin
              rearm = 1'b1;
            end
          end
        end
        ST_HOLD:  if (dl_expire) rearm = 1'b1;
        default:  st_d = ST_OFF;
      endcase
      if (rearm) begin
        st_d    = ST_ARMED;
        os_load = (xcnt_q == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q    <= ST_OFF;
      xcnt_q  <= '0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      if (xcnt_en) xcnt_q <= xcnt_d;
    end
  end

  assign scan_start = start_q;
  assign irq_masked = (st_q != ST_ARMED);
endmodule

// File: rtl/pen_scan_pacer_chk.sv
module pen_scan_pacer_chk #(
  parameter int INTERVAL_US = 10000,
  parameter int DUR_W       = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             scan_done,
  input logic [DUR_W-1:0] scan_dur_us,
  input logic             scan_start,
  input logic             irq_masked
);
  logic pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  pending_q <= 1'b0;
    else if (!en)                                pending_q <= 1'b0;
    else if (scan_done && (pending_q || scan_start)) pending_q <= 1'b0;
    else if (scan_start)                         pending_q <= 1'b1;
  end

  a_r2_masked_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> irq_masked);

  a_r2_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !scan_start);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |=> !scan_start);

  a_r3_mask_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |-> irq_masked);

  a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> !scan_start);

  a_r5_immediate_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && scan_done && en && (32'(scan_dur_us) >= 32'(INTERVAL_US)))
      |=> !irq_masked);
endmodule

bind pen_scan_pacer pen_scan_pacer_chk #(
  .INTERVAL_US(INTERVAL_US),
  .DUR_W(DUR_W)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .en(en),
  .scan_done(scan_done),
  .scan_dur_us(scan_dur_us),
  .scan_start(scan_start),
  .irq_masked(irq_masked)
);

// File: tb/sim_pen_scan_pacer.sv
module sim_pen_scan_pacer;
  localparam int C     = 4;
  localparam int IV    = 20;
  localparam int N     = 1000 * C;   // one-shot: 1 ms rounded up, in cycles
  localparam int NVEC  = 6;
  localparam int unsigned DUR_TAB  [NVEC] = '{3, 19, 20, 21, 65535, 10};
  localparam int unsigned HOLD_TAB [NVEC] = '{17, 1, 0, 0, 0, 10};

  logic        clk = 1'b0;
  logic        rst_n, en, pen_n, scan_done;
  logic [15:0] scan_dur_us;
  logic        scan_start, irq_masked;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  pen_scan_pacer #(.CLK_PER_US(C), .INTERVAL_US(IV), .DUR_W(16), .XCNT_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .pen_n(pen_n), .scan_done(scan_done),
    .scan_dur_us(scan_dur_us), .scan_start(scan_start), .irq_masked(irq_masked)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pen_pulse();
    @(negedge clk) pen_n = 1'b0;
    @(negedge clk) pen_n = 1'b1;
  endtask

  // called at a negedge; counts rising edges until scan_start is seen
  task automatic wait_start(input int lim, output int cyc, output bit seen);
    cyc = 0;
    do begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end while (!scan_start && cyc < lim);
    seen = scan_start;
  endtask

  // finishes the outstanding scan and measures edges until unmask
  task automatic done_and_hold(input int dur, output int m);
    repeat (2) @(negedge clk);
    scan_dur_us = 16'(dur);
    scan_done   = 1'b1;
    @(negedge clk) scan_done = 1'b0;
    m = 0;
    while (irq_masked && m < 100000) begin
      @(posedge clk);
      m++;
      @(negedge clk);
    end
  endtask

  task automatic count_starts(input int cycles, output int s);
    s = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (scan_start) s++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int  cyc, m, s, lo, hi;
    bit  seen;
    rst_n = 1'b0; en = 1'b0; pen_n = 1'b1; scan_done = 1'b0; scan_dur_us = '0;
    repeat (5) @(negedge clk);
    check(!scan_start && irq_masked, "R1 in reset", {scan_start, irq_masked}, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(irq_masked, "R1 disabled after reset", irq_masked, 1);

    // R2: pen ignored while disabled
    pen_n = 1'b0;
    count_starts(20, s);
    pen_n = 1'b1;
    repeat (4) @(negedge clk);
    check(s == 0, "R2 pen while disabled", s, 0);

    en = 1'b1;
    @(negedge clk);
    check(!irq_masked, "R2 unmask on enable", irq_masked, 0);

    // R3: latency through the synchronizer
    pen_n = 1'b0;
    wait_start(50, cyc, seen);
    check(seen && cyc == 3, "R3 start latency", cyc, 3);
    check(irq_masked, "R3 masked with start", irq_masked, 1);
    @(negedge clk);
    check(!scan_start, "R3 single pulse", scan_start, 0);

    // R4: pen held low, no done: no new start
    count_starts(100, s);
    pen_n = 1'b1;
    check(s == 0, "R4 one outstanding", s, 0);
    done_and_hold(0, m);
    check(m >= (IV - 1) * C + 1 && m <= IV * C, "R5 hold after dur 0", m, IV * C);

    // R5: table of scan durations and expected hold lengths
    for (int v = 0; v < NVEC; v++) begin
      pen_pulse();
      wait_start(50, cyc, seen);
      check(seen, "R3 start from pen pulse", seen, 1);
      done_and_hold(DUR_TAB[v], m);
      lo = (HOLD_TAB[v] == 0) ? 0 : (HOLD_TAB[v] - 1) * C + 1;
      hi = HOLD_TAB[v] * C;
      check(m >= lo && m <= hi, "R5 hold length", m, hi);
    end

    // R6: last entry re-armed from a hold; exact one-shot timing
    wait_start(N + 100, cyc, seen);
    check(seen && cyc == N, "R6 extra scan timing", cyc, N);
    done_and_hold(0, m);

    // R7: after the timer scan, silence
    count_starts(2 * N + 500, s);
    check(s == 0 && !irq_masked, "R7 no second timer scan", s, 0);

    // R8: pen during pending timer restarts it from the later re-arm
    pen_pulse();
    wait_start(50, cyc, seen);
    done_and_hold(0, m);
    repeat (1000) @(negedge clk);
    pen_pulse();
    wait_start(50, cyc, seen);
    check(seen, "R8 pen start while timer pending", seen, 1);
    done_and_hold(0, m);
    wait_start(N + 100, cyc, seen);
    check(seen && cyc == N, "R8 fresh timer after cancel", cyc, N);
    done_and_hold(0, m);

    // R10: pen arrives in the expiry cycle
    pen_pulse();
    wait_start(50, cyc, seen);
    done_and_hold(0, m);
    repeat (N - 3) @(posedge clk);
    @(negedge clk) pen_n = 1'b0;
    @(negedge clk) pen_n = 1'b1;
    wait_start(20, cyc, seen);
    check(seen && cyc == 2, "R10 coincident start", cyc, 2);
    @(negedge clk);
    check(!scan_start, "R10 single start", scan_start, 0);
    done_and_hold(0, m);
    wait_start(N + 100, cyc, seen);
    check(seen && cyc == N, "R10 treated as pen scan", cyc, N);
    done_and_hold(0, m);

    // R9: disable drops a pending timer
    pen_pulse();
    wait_start(50, cyc, seen);
    done_and_hold(0, m);
    repeat (500) @(negedge clk);
    en = 1'b0;
    repeat (50) @(negedge clk);
    check(irq_masked, "R2 masked while disabled", irq_masked, 1);
    en = 1'b1;
    @(negedge clk);
    check(!irq_masked, "R2 unmask on re-enable", irq_masked, 0);
    count_starts(N + 2000, s);
    check(s == 0, "R9 timer cancelled by disable", s, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule